// File: doc/BRIEF.md
# Ramp Configuration Register Block with Update Acknowledge

This block is a 32-bit memory-mapped register slave that stores the configuration words of a voltage/frequency ramp engine and applies them through a per-entry update handshake. Software programs a group of words, selects the group by writing its entry code into the update register, and then sets the update-enable bit. After a fixed latency the hardware raises a one-hot acknowledge bit in the upper half-word and copies that group's words into an "applied" shadow set, which stands in for the ramp datapath.

Acknowledges remain set until software writes a full zero to the update register. The whole acknowledge field then drops after a fixed latency. A command register provides a root-enable bit and a busy flag. The busy flag rises when root enable is written to 1 and clears by itself after a fixed number of cycles.

The bus port is a single request channel with valid/ready and a response channel with a valid strobe only. `req_ready` is held high, so a request is taken on every cycle in which `req_valid` is high. The response channel has no back-pressure: a read returns its data exactly one cycle after it is accepted, and the requester must take it in that cycle.

Top module: `rampcfg_regblock`

## Requirements
- R1: After reset every register reads zero, all applied shadow outputs are zero and `rsp_valid` is low.
- R2: `req_ready` is always 1. A read accepted on a clock edge gives `rsp_valid`=1 on the following cycle, with the register contents as they stood just before that edge. `rsp_valid` is 0 in every cycle that does not follow an accepted read.
- R3: The command register is at offset 0x00. Bit 1 is root enable (read/write) and bit 0 is busy (read-only). A write with bit 1 set raises busy for BUSY_CYC cycles (default 4) and then clears it. A new such write restarts the count. A write with bit 1 clear does not start busy.
- R4: Configuration words are plain 32-bit read/write storage. Frequency words are at 0x10 + 4·i for i < FREQ_N (default 8). Limit words are at 0x30 + 4·i for i < LIM_N (default 3). The link word is at 0x40 and the ramp-control word is at 0x50.
- R5: The update register is at 0x60. Bits 3:0 hold the entry code, bit 8 is update enable, bits 31:16 hold the read-only acknowledge field, and all other bits read 0. A write with bit 8 set launches an update for the code written in bits 3:0. Acknowledge bit 16+code rises SET_LAT clock edges (default 3) after the write's edge. A later launch that arrives while an update is still pending replaces it. Acknowledge bits never rise in any other way.
- R6: Acknowledge bits persist, including through nonzero writes that leave bit 8 clear. A write of exactly zero to 0x60 clears the whole acknowledge field CLR_LAT edges later (default 3). That write also discards any update still pending after its edge.
- R7: When an acknowledge rises, the words of its entry are copied into the applied outputs. Code 14 copies the frequency words, code 6 the limit words, code 3 the link word and code 2 the ramp-control word. Any other code sets its acknowledge bit but copies nothing, and applied outputs change at no other time.
- R8: If a configuration word is written on the same edge on which its entry's acknowledge rises, the applied copy takes the old value and storage keeps the new one.
- R9: The following reads return zero and writes to them change nothing: offsets that are not multiples of 4, 0x04–0x0C, 0x3C, 0x44–0x4C, 0x54–0x5C, 0x64, 0x68, and anything above 0x68.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_rdata | output | 32 | Read data |
| applied_freq | output | FREQ_N·32 | Applied frequency words, word i at bits 32·i+31:32·i |
| applied_limits | output | LIM_N·32 | Applied limit words, same packing |
| applied_link | output | 32 | Applied link word |
| applied_ramp | output | 32 | Applied ramp-control word |

## Verification
The two functions that can land on the same edge are a bus write to a configuration word and the copy of that word's group into the applied set when its acknowledge rises. A second same-edge case is a zero write to the update register arriving on the edge where a pending acknowledge completes. The bench provokes each one by launching an update, idling exactly SET_LAT−1 cycles, and then issuing the colliding write. For the first case it judges that the applied output holds the old word while a read of storage returns the new one. For the second it judges that the acknowledge still rises and is then cleared CLR_LAT edges later. A cycle-accurate behavioural model compares the responses and the applied outputs on every clock.

// File: rtl/rampcfg_pkg.sv
package rampcfg_pkg;

  localparam int unsigned DATA_W = 32;

  // register offsets (bytes)
  localparam int unsigned OFS_CMD  = 32'h00;
  localparam int unsigned OFS_FREQ = 32'h10;
  localparam int unsigned OFS_LIM  = 32'h30;
  localparam int unsigned OFS_LINK = 32'h40;
  localparam int unsigned OFS_RAMP = 32'h50;
  localparam int unsigned OFS_UPD  = 32'h60;

  // update register fields
  localparam int unsigned UPD_EN_BIT = 8;
  localparam int unsigned ACK_LSB    = 16;
  localparam int unsigned CODE_W     = 4;
  localparam int unsigned ACK_W      = 16;

  // entry codes
  localparam logic [CODE_W-1:0] ENT_RAMP = 4'd2;
  localparam logic [CODE_W-1:0] ENT_LINK = 4'd3;
  localparam logic [CODE_W-1:0] ENT_LIM  = 4'd6;
  localparam logic [CODE_W-1:0] ENT_FREQ = 4'd14;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CMD, SEL_FREQ, SEL_LIM, SEL_LINK, SEL_RAMP, SEL_UPD
  } sel_e;

  typedef struct packed {
    sel_e       sel;
    logic [2:0] idx;
  } dec_t;

endpackage

// File: rtl/rc_delay_timer.sv
module rc_delay_timer #(
  parameter int unsigned LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic active,
  output logic fire
);
  localparam int unsigned CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (start)           cnt_q <= CW'(LAT);
    else if (cancel)          cnt_q <= '0;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
  assign fire   = (cnt_q == CW'(1));
endmodule

// File: rtl/rc_addr_decode.sv
module rc_addr_decode import rampcfg_pkg::*; #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned FREQ_N = 8,
  parameter int unsigned LIM_N  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  logic [31:0] a;

  always_comb begin
    a       = 32'(addr);
    dec.sel = SEL_NONE;
    dec.idx = '0;
    if (a[1:0] == 2'b00) begin
      if (a == OFS_CMD) begin
        dec.sel = SEL_CMD;
      end else if (a >= OFS_FREQ && a < OFS_FREQ + 4 * FREQ_N) begin
        dec.sel = SEL_FREQ;
        dec.idx = 3'((a - OFS_FREQ) >> 2);
      end else if (a >= OFS_LIM && a < OFS_LIM + 4 * LIM_N) begin
        dec.sel = SEL_LIM;
        dec.idx = 3'((a - OFS_LIM) >> 2);
      end else if (a == OFS_LINK) begin
        dec.sel = SEL_LINK;
      end else if (a == OFS_RAMP) begin
        dec.sel = SEL_RAMP;
      end else if (a == OFS_UPD) begin
        dec.sel = SEL_UPD;
      end
    end
  end
endmodule

// File: rtl/rc_cfg_bank.sv
module rc_cfg_bank import rampcfg_pkg::*; #(
  parameter int unsigned FREQ_N = 8,
  parameter int unsigned LIM_N  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  dec_t                     dec,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     apply_en,
  input  logic [CODE_W-1:0]        apply_code,
  output logic [DATA_W-1:0]        rd_word,
  output logic [FREQ_N*DATA_W-1:0] applied_freq,
  output logic [LIM_N*DATA_W-1:0]  applied_lim,
  output logic [DATA_W-1:0]        applied_link,
  output logic [DATA_W-1:0]        applied_ramp
);
  localparam int unsigned DW = DATA_W;

  logic [FREQ_N*DW-1:0] freq_flat;
  logic [LIM_N*DW-1:0]  lim_flat;
  logic [DW-1:0]        link_q, ramp_q;

  wire ap_freq = apply_en && (apply_code == ENT_FREQ);
  wire ap_lim  = apply_en && (apply_code == ENT_LIM);
  wire ap_link = apply_en && (apply_code == ENT_LINK);
  wire ap_ramp = apply_en && (apply_code == ENT_RAMP);

  for (genvar g = 0; g < FREQ_N; g++) begin : g_freq
    logic [DW-1:0] word_q, shadow_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q   <= '0;
        shadow_q <= '0;
      end else begin
        if (wr_en && dec.sel == SEL_FREQ && dec.idx == 3'(g)) word_q <= wdata;
        if (ap_freq) shadow_q <= word_q;
      end
    end
    assign freq_flat[g*DW +: DW]    = word_q;
    assign applied_freq[g*DW +: DW] = shadow_q;
  end

  for (genvar g = 0; g < LIM_N; g++) begin : g_lim
    logic [DW-1:0] word_q, shadow_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q   <= '0;
        shadow_q <= '0;
      end else begin
        if (wr_en && dec.sel == SEL_LIM && dec.idx == 3'(g)) word_q <= wdata;
        if (ap_lim) shadow_q <= word_q;
      end
    end
    assign lim_flat[g*DW +: DW]    = word_q;
    assign applied_lim[g*DW +: DW] = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q       <= '0;
      ramp_q       <= '0;
      applied_link <= '0;
      applied_ramp <= '0;
    end else begin
      if (wr_en && dec.sel == SEL_LINK) link_q <= wdata;
      if (wr_en && dec.sel == SEL_RAMP) ramp_q <= wdata;
      if (ap_link) applied_link <= link_q;
      if (ap_ramp) applied_ramp <= ramp_q;
    end
  end

  always_comb begin
    case (dec.sel)
      SEL_FREQ: rd_word = freq_flat[int'(dec.idx)*DW +: DW];
      SEL_LIM:  rd_word = lim_flat[int'(dec.idx)*DW +: DW];
      SEL_LINK: rd_word = link_q;
      SEL_RAMP: rd_word = ramp_q;
      default:  rd_word = '0;
    endcase
  end

  // R7 R8
  apply_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ap_freq |=> applied_freq == $past(freq_flat));

  // R7
  link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ap_link |=> $stable(applied_link));
endmodule

// File: rtl/rc_update_ctrl.sv
module rc_update_ctrl import rampcfg_pkg::*; #(
  parameter int unsigned SET_LAT = 3,
  parameter int unsigned CLR_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] upd_rd,
  output logic              apply_en,
  output logic [CODE_W-1:0] apply_code
);
  logic [CODE_W-1:0] code_q, pend_q;
  logic              en_q;
  logic [ACK_W-1:0]  ack_q, ack_d;
  logic              set_active, set_fire, clr_active, clr_fire;

  wire trig = wr_en && wdata[UPD_EN_BIT];
  wire zero = wr_en && (wdata == '0);

  rc_delay_timer #(.LAT(SET_LAT)) u_set_tmr (
    .clk(clk), .rst_n(rst_n), .start(trig), .cancel(zero),
    .active(set_active), .fire(set_fire));

  rc_delay_timer #(.LAT(CLR_LAT)) u_clr_tmr (
    .clk(clk), .rst_n(rst_n), .start(zero), .cancel(1'b0),
    .active(clr_active), .fire(clr_fire));

  always_comb begin
    ack_d = clr_fire ? '0 : ack_q;
    if (set_fire) ack_d[pend_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      en_q   <= 1'b0;
      pend_q <= '0;
      ack_q  <= '0;
    end else begin
      ack_q <= ack_d;
      if (wr_en) begin
        code_q <= wdata[CODE_W-1:0];
        en_q   <= wdata[UPD_EN_BIT];
      end
      if (trig) pend_q <= wdata[CODE_W-1:0];
    end
  end

  assign upd_rd     = {ack_q, 7'b0, en_q, 4'b0, code_q};
  assign apply_en   = set_fire;
  assign apply_code = pend_q;

  // R5
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_fire |=> ack_q[$past(pend_q)]);

  // R5
  ack_no_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_fire |=> (ack_q & ~$past(ack_q)) == '0);

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire && !set_fire |=> ack_q == '0);

  // R6
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero |=> !set_active && clr_active);
endmodule

// File: rtl/rampcfg_regblock.sv
module rampcfg_regblock import rampcfg_pkg::*; #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned FREQ_N   = 8,
  parameter int unsigned LIM_N    = 3,
  parameter int unsigned BUSY_CYC = 4,
  parameter int unsigned SET_LAT  = 3,
  parameter int unsigned CLR_LAT  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [31:0]              req_wdata,
  output logic                     rsp_valid,
  output logic [31:0]              rsp_rdata,
  output logic [FREQ_N*32-1:0]     applied_freq,
  output logic [LIM_N*32-1:0]      applied_limits,
  output logic [31:0]              applied_link,
  output logic [31:0]              applied_ramp
);
  localparam int unsigned DW = DATA_W;

  dec_t              dec;
  logic              root_en_q, busy, busy_done;
  logic [DW-1:0]     bank_rd, upd_rd, rd_mux;
  logic              apply_en;
  logic [CODE_W-1:0] apply_code;

  wire wr         = req_valid && req_write;
  wire rd         = req_valid && !req_write;
  wire busy_start = wr && dec.sel == SEL_CMD && req_wdata[1];

  assign req_ready = 1'b1;

  rc_addr_decode #(.ADDR_W(ADDR_W), .FREQ_N(FREQ_N), .LIM_N(LIM_N)) u_dec (
    .addr(req_addr), .dec(dec));

  rc_delay_timer #(.LAT(BUSY_CYC)) u_busy_tmr (
    .clk(clk), .rst_n(rst_n), .start(busy_start), .cancel(1'b0),
    .active(busy), .fire(busy_done));

  rc_cfg_bank #(.FREQ_N(FREQ_N), .LIM_N(LIM_N)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr), .dec(dec), .wdata(req_wdata),
    .apply_en(apply_en), .apply_code(apply_code), .rd_word(bank_rd),
    .applied_freq(applied_freq), .applied_lim(applied_limits),
    .applied_link(applied_link), .applied_ramp(applied_ramp));

  rc_update_ctrl #(.SET_LAT(SET_LAT), .CLR_LAT(CLR_LAT)) u_upd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr && dec.sel == SEL_UPD),
    .wdata(req_wdata), .upd_rd(upd_rd), .apply_en(apply_en),
    .apply_code(apply_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        root_en_q <= 1'b0;
    else if (wr && dec.sel == SEL_CMD) root_en_q <= req_wdata[1];
  end

  always_comb begin
    case (dec.sel)
      SEL_CMD:                               rd_mux = {30'b0, root_en_q, busy};
      SEL_FREQ, SEL_LIM, SEL_LINK, SEL_RAMP: rd_mux = bank_rd;
      SEL_UPD:                               rd_mux = upd_rd;
      default:                               rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
    end
  end

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_start |=> busy);

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_done && !busy_start |=> !busy);

  // R2
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);

  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd && dec.sel == SEL_NONE |=> rsp_rdata == '0);
endmodule

// File: tb/sim_rampcfg_regblock.sv
`timescale 1ns/1ps
module sim_rampcfg_regblock;
  localparam int FN = 8, LN = 3, BUSY = 4, SLAT = 3, CLAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata, applied_link, applied_ramp;
  logic [FN*32-1:0] applied_freq;
  logic [LN*32-1:0] applied_limits;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rampcfg_regblock #(.ADDR_W(8), .FREQ_N(FN), .LIM_N(LN), .BUSY_CYC(BUSY),
                     .SET_LAT(SLAT), .CLR_LAT(CLAT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .applied_freq(applied_freq),
    .applied_limits(applied_limits), .applied_link(applied_link),
    .applied_ramp(applied_ramp));

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_freq[FN], m_lim[LN], m_apf[FN], m_apl[LN];
  bit [31:0] m_link, m_ramp, m_apk, m_apr, m_rsp_d;
  bit [15:0] m_ack;
  bit [3:0]  m_code, m_pcode;
  bit        m_root, m_en, m_rsp_v;
  int        m_busy, m_set, m_clr;

  function automatic bit [31:0] m_read(input bit [7:0] a);
    if (a[1:0] != 0) return 0;
    if (a == 8'h00) return {30'b0, m_root, m_busy > 0};
    if (a >= 8'h10 && a < 8'h10 + 4*FN) return m_freq[(a - 8'h10) / 4];
    if (a >= 8'h30 && a < 8'h30 + 4*LN) return m_lim[(a - 8'h30) / 4];
    if (a == 8'h40) return m_link;
    if (a == 8'h50) return m_ramp;
    if (a == 8'h60) return {m_ack, 7'b0, m_en, 4'b0, m_code};
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_freq[i]) begin m_freq[i] = 0; m_apf[i] = 0; end
      foreach (m_lim[i])  begin m_lim[i] = 0;  m_apl[i] = 0; end
      m_link = 0; m_ramp = 0; m_apk = 0; m_apr = 0; m_ack = 0;
      m_code = 0; m_pcode = 0; m_root = 0; m_en = 0;
      m_busy = 0; m_set = 0; m_clr = 0; m_rsp_v = 0; m_rsp_d = 0;
    end else begin
      bit sf, cf;
      bit [31:0] rdv;
      rdv = m_read(req_addr);
      sf = (m_set == 1);
      cf = (m_clr == 1);
      if (sf) begin
        case (m_pcode)
          4'd14: foreach (m_apf[i]) m_apf[i] = m_freq[i];
          4'd6:  foreach (m_apl[i]) m_apl[i] = m_lim[i];
          4'd3:  m_apk = m_link;
          4'd2:  m_apr = m_ramp;
          default: ;
        endcase
      end
      if (cf) m_ack = 0;
      if (sf) m_ack[m_pcode] = 1'b1;
      if (m_busy > 0) m_busy--;
      if (m_set > 0) m_set--;
      if (m_clr > 0) m_clr--;
      if (req_valid && req_write && req_addr[1:0] == 0) begin
        if (req_addr == 8'h00) begin
          m_root = req_wdata[1];
          if (req_wdata[1]) m_busy = BUSY;
        end else if (req_addr >= 8'h10 && req_addr < 8'h10 + 4*FN)
          m_freq[(req_addr - 8'h10) / 4] = req_wdata;
        else if (req_addr >= 8'h30 && req_addr < 8'h30 + 4*LN)
          m_lim[(req_addr - 8'h30) / 4] = req_wdata;
        else if (req_addr == 8'h40) m_link = req_wdata;
        else if (req_addr == 8'h50) m_ramp = req_wdata;
        else if (req_addr == 8'h60) begin
          m_code = req_wdata[3:0];
          m_en   = req_wdata[8];
          if (req_wdata[8]) begin m_set = SLAT; m_pcode = req_wdata[3:0]; end
          if (req_wdata == 0) begin m_set = 0; m_clr = CLAT; end
        end
      end
      m_rsp_v = req_valid && !req_write;
      if (m_rsp_v) m_rsp_d = rdv;
    end
  end

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check32("R2 req_ready", {31'b0, req_ready}, 32'd1);
      check32("R2 rsp_valid", {31'b0, rsp_valid}, {31'b0, m_rsp_v});
      if (m_rsp_v) check32("R2 rsp_rdata", rsp_rdata, m_rsp_d);
      for (int i = 0; i < FN; i++) check32("R7 applied_freq", applied_freq[i*32 +: 32], m_apf[i]);
      for (int i = 0; i < LN; i++) check32("R7 applied_limits", applied_limits[i*32 +: 32], m_apl[i]);
      check32("R7 applied_link", applied_link, m_apk);
      check32("R7 applied_ramp", applied_ramp, m_apr);
    end
  end

  // ---------------- stimulus helpers (called at a negedge) ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] exp, input string tag);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check32(tag, rsp_rdata, exp);
    check32(tag, {31'b0, rsp_valid}, 32'd1);
  endtask

  task automatic idle();
    req_valid = 0;
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check32("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check32("R1 applied_link", applied_link, 0);
    check32("R1 applied_freq word0", applied_freq[31:0], 0);
    rd_exp(8'h00, 0, "R1 cmd");
    rd_exp(8'h10, 0, "R1 freq0");
    rd_exp(8'h38, 0, "R1 lim2");
    rd_exp(8'h60, 0, "R1 upd");

    // R4 storage
    for (int i = 0; i < FN; i++) wr(8'(8'h10 + 4*i), 32'h1000_0000 + i * 32'h111);
    for (int i = 0; i < LN; i++) wr(8'(8'h30 + 4*i), 32'hA0 + i);
    wr(8'h40, 32'h00C0_FFEE);
    wr(8'h50, 32'h0000_0800);
    for (int i = 0; i < FN; i++) rd_exp(8'(8'h10 + 4*i), 32'h1000_0000 + i * 32'h111, "R4 freq");
    for (int i = 0; i < LN; i++) rd_exp(8'(8'h30 + 4*i), 32'hA0 + i, "R4 lim");
    rd_exp(8'h40, 32'h00C0_FFEE, "R4 link");
    rd_exp(8'h50, 32'h0000_0800, "R4 ramp");

    // R3 busy timing, restart, bit 0 read-only
    wr(8'h00, 32'h2);
    for (int i = 0; i < BUSY; i++) rd_exp(8'h00, 32'h3, "R3 busy high");
    rd_exp(8'h00, 32'h2, "R3 busy cleared");
    wr(8'h00, 32'h1);
    rd_exp(8'h00, 32'h0, "R3 busy not set by bit0");
    wr(8'h00, 32'h2);
    rd_exp(8'h00, 32'h3, "R3 restart a");
    rd_exp(8'h00, 32'h3, "R3 restart b");
    wr(8'h00, 32'h2);
    for (int i = 0; i < BUSY; i++) rd_exp(8'h00, 32'h3, "R3 restart busy");
    rd_exp(8'h00, 32'h2, "R3 restart cleared");

    // R5 R7 frequency entry
    wr(8'h60, 32'h10E);
    for (int i = 0; i < SLAT; i++) rd_exp(8'h60, 32'h0000_010E, "R5 ack not yet");
    rd_exp(8'h60, 32'h4000_010E, "R5 ack bit30");
    for (int i = 0; i < FN; i++)
      check32("R7 freq applied", applied_freq[i*32 +: 32], 32'h1000_0000 + i * 32'h111);

    // R6 nonzero write without enable keeps ack; R5 ack field read-only
    wr(8'h60, 32'h5);
    rd_exp(8'h60, 32'h4000_0005, "R6 ack persists");
    wr(8'h60, 32'hFFFF_0000);
    rd_exp(8'h60, 32'h4000_0000, "R5 ack read-only");

    // R6 clear by zero write
    wr(8'h60, 32'h0);
    for (int i = 0; i < CLAT; i++) rd_exp(8'h60, 32'h4000_0000, "R6 ack before clear");
    rd_exp(8'h60, 32'h0, "R6 ack cleared");

    // R7 limits, link, unknown code
    wr(8'h60, 32'h106);
    for (int i = 0; i < SLAT; i++) idle();
    rd_exp(8'h60, 32'h0040_0106, "R7 limits ack");
    for (int i = 0; i < LN; i++) check32("R7 limits applied", applied_limits[i*32 +: 32], 32'hA0 + i);
    wr(8'h60, 32'h103);
    for (int i = 0; i < SLAT; i++) idle();
    rd_exp(8'h60, 32'h0048_0103, "R7 link ack");
    check32("R7 link applied", applied_link, 32'h00C0_FFEE);
    wr(8'h60, 32'h109);
    for (int i = 0; i < SLAT; i++) idle();
    rd_exp(8'h60, 32'h0248_0109, "R7 unknown code ack");
    check32("R7 unknown code copies nothing", applied_ramp, 32'h0);

    // R8 word write on the completion edge
    wr(8'h60, 32'h102);
    for (int i = 0; i < SLAT - 1; i++) idle();
    wr(8'h50, 32'h0000_0C00);
    check32("R8 applied keeps old", applied_ramp, 32'h0000_0800);
    rd_exp(8'h50, 32'h0000_0C00, "R8 storage new");
    rd_exp(8'h60, 32'h024C_0102, "R8 ack ramp");

    // R6 zero write on the completion edge
    wr(8'h10, 32'h0000_55AA);
    wr(8'h60, 32'h10E);
    for (int i = 0; i < SLAT - 1; i++) idle();
    wr(8'h60, 32'h0);
    for (int i = 0; i < CLAT; i++) rd_exp(8'h60, 32'h424C_0000, "R6 ack rises at zero edge");
    rd_exp(8'h60, 32'h0, "R6 cleared after zero");
    check32("R7 freq0 re-applied", applied_freq[31:0], 32'h0000_55AA);

    // R6 cancel pending update
    wr(8'h40, 32'h0000_1234);
    wr(8'h60, 32'h103);
    wr(8'h60, 32'h0);
    for (int i = 0; i < SLAT + CLAT; i++) rd_exp(8'h60, 32'h0, "R6 cancelled");
    check32("R6 link not applied", applied_link, 32'h00C0_FFEE);

    // R5 relaunch replaces pending code
    wr(8'h60, 32'h103);
    wr(8'h60, 32'h102);
    for (int i = 0; i < SLAT; i++) idle();
    rd_exp(8'h60, 32'h0004_0102, "R5 relaunch only code2");
    check32("R5 relaunch link untouched", applied_link, 32'h00C0_FFEE);
    check32("R7 ramp applied", applied_ramp, 32'h0000_0C00);
    wr(8'h60, 32'h0);
    for (int i = 0; i < CLAT; i++) idle();

    // R9 unmapped addresses
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h54, 32'hFFFF_FFFF);
    wr(8'h64, 32'hFFFF_FFFF);
    wr(8'h68, 32'hFFFF_FFFF);
    wr(8'h12, 32'hFFFF_FFFF);
    wr(8'h62, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rd_exp(8'h04, 0, "R9 0x04");
    rd_exp(8'h3C, 0, "R9 0x3C");
    rd_exp(8'h64, 0, "R9 0x64");
    rd_exp(8'h68, 0, "R9 0x68");
    rd_exp(8'h12, 0, "R9 misaligned");
    rd_exp(8'hFC, 0, "R9 0xFC");
    rd_exp(8'h10, 32'h0000_55AA, "R9 freq0 untouched");
    rd_exp(8'h38, 32'hA2, "R9 lim2 untouched");
    rd_exp(8'h60, 32'h0, "R9 upd untouched");
    rd_exp(8'h00, 32'h2, "R9 cmd untouched");
    idle();
    idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule